// File: doc/BRIEF.md
# IDEA Encryption Subkey Expander

This block turns a 128-bit IDEA cipher key into the 52 sixteen-bit encryption subkeys. It stores them in an internal table that the host reads by index. The cipher datapath needs six subkeys for each of its eight full rounds and four for the closing half round. It fetches them from the table through a combinational read port after the expansion has finished.

The host presents a key and pulses `start` for one clock. The block captures the key on that edge. In the next cycle it copies the eight key words into table slots 0 to 7. It then derives one new word per clock for slots 8 to 51. Each new word comes from two words of the previous group of eight, through a 16-bit left shift by 9 and a 16-bit right shift by 7 that are ORed together. This gives the same result as rotating the whole key left by 25 bits for each group, without a 128-bit rotator. `busy` is high during the work. `done` rises when the last slot has been written and stays high until the next accepted start.

Top module: `idea_key_expander`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every index 0 to 63 reads 0000h.
- R2: A one-cycle `start` while `busy` is 0 is accepted. `busy` is 1 in the following cycle and `done` is 0. The key is taken from `key` at that edge, so later changes on `key` do not affect the result.
- R3: Subkey #0 is key bits [127:112], subkey #1 is [111:96], and so on down to subkey #7 = [15:0], all copied unchanged.
- R4: For index i from 8 to 51, subkey #i equals 16-bit word (i mod 8) of the key rotated left by 25*floor(i/8) bits, where word 0 is the most significant. With key words 0001h..0008h, #8 = 0400h, #9 = 0600h, #14 = 1000h and #15 = 0200h.
- R5: `busy` stays high for exactly 45 consecutive cycles after an accepted start. `done` rises in the cycle `busy` falls and stays high until the next accepted start.
- R6: A `start` that arrives while `busy` is 1 is ignored. The run length and every stored subkey are unchanged.
- R7: `rd_data` follows `rd_idx` combinationally. Any index from 52 to 63 returns 0000h.
- R8: `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to expand `key` |
| key | input | 128 | Cipher key, word 0 in bits [127:112] |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | Table complete and valid |
| rd_idx | input | 6 | Subkey index to read |
| rd_data | output | 16 | Subkey at `rd_idx`, 0000h above 51 |

## Verification
The bench expands several keys and compares all 52 table entries with a model that rotates the full 128-bit key. The keys are chosen to expose the wrap inside each group of eight: slots with i mod 8 equal to 6 and 7 draw on word 0 of the same group. A design that took those source words from the next group would store wrong words at #14, #15 and every eighth slot after them. A second start is pulsed in mid-run with a different key, and the key input is also changed right after a start. A design that restarted or sampled the key late would then show a run longer than 45 cycles or a table built from the wrong key. A sweep of indices 52 to 63 catches a read port that aliases into the table instead of returning zero.

// File: rtl/ikx_pkg.sv
package ikx_pkg;
    parameter int unsigned SK_WORD_W  = 16;
    parameter int unsigned SK_KEY_W   = 128;
    parameter int unsigned SK_ROT     = 25;
    parameter int unsigned SK_COUNT   = 52;
    parameter int unsigned SK_IDX_W   = 6;

    localparam int unsigned SK_KEY_WORDS = SK_KEY_W / SK_WORD_W;
    localparam int unsigned SK_LANE_W    = $clog2(SK_KEY_WORDS);
    localparam int unsigned SK_SHL       = SK_ROT % SK_WORD_W;
    localparam int unsigned SK_SHR       = SK_WORD_W - SK_SHL;
    localparam int unsigned SK_RUN_CYC   = SK_COUNT - SK_KEY_WORDS + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_GEN  = 2'd2,
        ST_DONE = 2'd3
    } ikx_state_e;
endpackage

// File: rtl/ikx_ctrl.sv
module ikx_ctrl
    import ikx_pkg::*;
#(
    parameter int unsigned KEY_W = SK_KEY_W,
    parameter int unsigned IDX_W = SK_IDX_W,
    parameter int unsigned COUNT = SK_COUNT,
    parameter int unsigned WORDS = SK_KEY_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic [KEY_W-1:0] load_key_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o
);
    localparam logic [IDX_W-1:0] FIRST_GEN = IDX_W'(WORDS);
    localparam logic [IDX_W-1:0] LAST_GEN  = IDX_W'(COUNT - 1);

    typedef struct packed {
        ikx_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [KEY_W-1:0] key;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    ctl_d.st  = ST_LOAD;
                    ctl_d.key = key_i;
                end
            end
            ST_LOAD: begin
                ctl_d.st  = ST_GEN;
                ctl_d.idx = FIRST_GEN;
            end
            ST_GEN: begin
                if (ctl_q.idx == LAST_GEN) begin
                    ctl_d.st = ST_DONE;
                end else begin
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, key: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o     = (ctl_q.st == ST_LOAD) || (ctl_q.st == ST_GEN);
    assign done_o     = (ctl_q.st == ST_DONE);
    assign load_o     = (ctl_q.st == ST_LOAD);
    assign load_key_o = ctl_q.key;
    assign wr_en_o    = (ctl_q.st == ST_GEN);
    assign wr_idx_o   = ctl_q.idx;
endmodule

// File: rtl/ikx_mix.sv
module ikx_mix
    import ikx_pkg::*;
#(
    parameter int unsigned WORD_W = SK_WORD_W,
    parameter int unsigned IDX_W  = SK_IDX_W,
    parameter int unsigned LANE_W = SK_LANE_W,
    parameter int unsigned SHL    = SK_SHL,
    parameter int unsigned SHR    = SK_SHR
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [IDX_W-1:0]  src_a_o,
    output logic [IDX_W-1:0]  src_b_o,
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int unsigned GRP_W = IDX_W - LANE_W;

    logic [LANE_W-1:0] lane, lane_a, lane_b;
    logic [GRP_W-1:0]  grp_prev;

    always_comb begin
        lane     = idx_i[LANE_W-1:0];
        lane_a   = lane + LANE_W'(1);
        lane_b   = lane + LANE_W'(2);
        grp_prev = idx_i[IDX_W-1:LANE_W] - GRP_W'(1);
        src_a_o  = {grp_prev, lane_a};
        src_b_o  = {grp_prev, lane_b};
        word_o   = (word_a_i << SHL) | (word_b_i >> SHR);
    end
endmodule

// File: rtl/ikx_store.sv
module ikx_store
    import ikx_pkg::*;
#(
    parameter int unsigned WORD_W = SK_WORD_W,
    parameter int unsigned KEY_W  = SK_KEY_W,
    parameter int unsigned IDX_W  = SK_IDX_W,
    parameter int unsigned COUNT  = SK_COUNT,
    parameter int unsigned WORDS  = SK_KEY_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [KEY_W-1:0]  load_key_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    output logic [WORD_W-1:0] ra_data_o,
    input  logic [IDX_W-1:0]  rb_idx_i,
    output logic [WORD_W-1:0] rb_data_o,
    input  logic [IDX_W-1:0]  rh_idx_i,
    output logic [WORD_W-1:0] rh_data_o
);
    logic [WORD_W-1:0] mem_d [COUNT];
    logic [WORD_W-1:0] mem_q [COUNT];

    function automatic logic [WORD_W-1:0] fetch(input logic [IDX_W-1:0] ix,
                                                input logic [WORD_W-1:0] tbl [COUNT]);
        logic [WORD_W-1:0] val;
        val = '0;
        for (int e = 0; e < int'(COUNT); e++) begin
            if (ix == IDX_W'(e)) val = tbl[e];
        end
        return val;
    endfunction

    always_comb begin
        for (int e = 0; e < int'(COUNT); e++) mem_d[e] = mem_q[e];
        if (load_i) begin
            for (int w = 0; w < int'(WORDS); w++) begin
                mem_d[w] = load_key_i[KEY_W-1-w*WORD_W -: WORD_W];
            end
        end
        if (wr_en_i) begin
            for (int e = 0; e < int'(COUNT); e++) begin
                if (wr_idx_i == IDX_W'(e)) mem_d[e] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < int'(COUNT); e++) mem_q[e] <= '0;
        end else begin
            for (int e = 0; e < int'(COUNT); e++) mem_q[e] <= mem_d[e];
        end
    end

    assign ra_data_o = fetch(ra_idx_i, mem_q);
    assign rb_data_o = fetch(rb_idx_i, mem_q);
    assign rh_data_o = fetch(rh_idx_i, mem_q);
endmodule

// File: rtl/idea_key_expander.sv
module idea_key_expander
    import ikx_pkg::*;
#(
    parameter int unsigned WORD_W = SK_WORD_W,
    parameter int unsigned KEY_W  = SK_KEY_W,
    parameter int unsigned IDX_W  = SK_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEY_W-1:0]  key,
    output logic              busy,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic              load_w, wr_en_w;
    logic [KEY_W-1:0]  load_key_w;
    logic [IDX_W-1:0]  wr_idx_w, src_a_w, src_b_w;
    logic [WORD_W-1:0] word_a_w, word_b_w, new_word_w;

    ikx_ctrl #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .key_i(key),
        .busy_o(busy), .done_o(done), .load_o(load_w), .load_key_o(load_key_w),
        .wr_en_o(wr_en_w), .wr_idx_o(wr_idx_w)
    );

    ikx_mix #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_mix (
        .idx_i(wr_idx_w), .src_a_o(src_a_w), .src_b_o(src_b_w),
        .word_a_i(word_a_w), .word_b_i(word_b_w), .word_o(new_word_w)
    );

    ikx_store #(.WORD_W(WORD_W), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .load_key_i(load_key_w),
        .wr_en_i(wr_en_w), .wr_idx_i(wr_idx_w), .wr_data_i(new_word_w),
        .ra_idx_i(src_a_w), .ra_data_o(word_a_w),
        .rb_idx_i(src_b_w), .rb_data_o(word_b_w),
        .rh_idx_i(rd_idx), .rh_data_o(rd_data)
    );
endmodule

// File: rtl/ikx_chk.sv
module ikx_chk
    import ikx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [5:0]  rd_idx,
    input logic [15:0] rd_data
);
    logic [6:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (!busy && start) begin
            run_len_q <= '0;
        end else if (busy) begin
            run_len_q <= run_len_q + 7'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done)); // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done)); // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len_q == 7'(SK_RUN_CYC))); // R5
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R5
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_len_q < 7'(SK_RUN_CYC - 1)) |=> busy); // R6
    AST_HIGH_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= 6'(SK_COUNT)) |-> (rd_data == 16'h0000)); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8
endmodule

bind idea_key_expander ikx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/sim_idea_key_expander.sv
module sim_idea_key_expander;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic         busy, done;
    logic [5:0]   rd_idx = '0;
    logic [15:0]  rd_data;

    int checks = 0;
    int errors = 0;

    idea_key_expander u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_sk(input logic [127:0] k, input int i);
        logic [127:0] r;
        r = k;
        for (int n = 0; n < i / 8; n++) r = {r[102:0], r[127:103]};
        return r[127 - 16*(i % 8) -: 16];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic read_sk(input int i, output logic [15:0] v);
        rd_idx = 6'(i);
        #1;
        v = rd_data;
    endtask

    // mode 0: plain, 1: key input changes after start (R2), 2: second start mid-run (R6)
    task automatic run_key(input logic [127:0] k, input logic [127:0] other, input int mode);
        int len;
        logic [15:0] v;
        @(negedge clk);
        key = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mode == 1) key = other;
        check("R2", {31'd0, busy}, 32'd1, "busy after start");
        check("R2", {31'd0, done}, 32'd0, "done cleared after start");
        len = 1;
        while (len < 200) begin
            if (mode == 2 && len == 10) begin
                key = other;
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (!busy) break;
            len++;
        end
        check(mode == 2 ? "R6" : "R5", len, 45, "busy cycle count");
        check("R5", {31'd0, done}, 32'd1, "done after run");
        for (int i = 0; i < 52; i++) begin
            read_sk(i, v);
            check(i < 8 ? "R3" : "R4", {16'd0, v}, {16'd0, model_sk(k, i)},
                  $sformatf("subkey %0d", i));
        end
        repeat (3) @(negedge clk);
        check("R5", {31'd0, done}, 32'd1, "done held while idle");
    endtask

    initial begin
        logic [15:0] v;
        logic [127:0] k1, lf;
        k1 = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 64; i++) begin
            read_sk(i, v);
            check("R1", {16'd0, v}, 32'd0, $sformatf("reset read %0d", i));
        end
        check("R1", {30'd0, busy, done}, 32'd0, "flags during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {30'd0, busy, done}, 32'd0, "flags after reset");

        run_key(k1, '0, 0);
        read_sk(8, v);  check("R4", {16'd0, v}, 32'h0400, "known subkey 8");
        read_sk(9, v);  check("R4", {16'd0, v}, 32'h0600, "known subkey 9");
        read_sk(14, v); check("R4", {16'd0, v}, 32'h1000, "known subkey 14");
        read_sk(15, v); check("R4", {16'd0, v}, 32'h0200, "known subkey 15");
        read_sk(0, v);  check("R3", {16'd0, v}, 32'h0001, "known subkey 0");
        read_sk(7, v);  check("R3", {16'd0, v}, 32'h0008, "known subkey 7");

        run_key({128{1'b1}}, '0, 0);
        run_key({1'b1, 127'd0}, '0, 0);
        run_key({8{16'hA5C3}}, '0, 0);
        lf = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        for (int r = 0; r < 4; r++) begin
            lf = {lf[126:0], lf[127] ^ lf[125] ^ lf[100] ^ lf[98]} ^ {lf[63:0], lf[127:64]};
            run_key(lf, '0, 0);
        end
        run_key(k1, {128{1'b1}}, 1);
        run_key({8{16'h8001}}, k1, 2);

        for (int i = 52; i < 64; i++) begin
            read_sk(i, v);
            check("R7", {16'd0, v}, 32'd0, $sformatf("high index %0d", i));
        end
        read_sk(3, v);
        check("R7", {16'd0, v}, {16'd0, model_sk({8{16'h8001}}, 3)}, "read follows index");
        check("R8", {30'd0, busy, done}, 32'd1, "flags exclusive at rest");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule